// File: doc/BRIEF.md
# ZVS Full-Bridge Gate Timing Generator

This block produces the four gate commands of a zero-voltage-switching full bridge from one clock. A cycle counter forms an oscillator whose period is a charge interval followed by a deadtime interval. Two consecutive oscillator periods make one bridge cycle: the first serves the left lower switch, the second the right lower switch. The upper pair runs at a fixed half-cycle duty and swaps inside each deadtime, a programmable fraction ahead of the end of the deadtime. The lower pair is modulated on its trailing edge by a duty command, cut short by a current-limit flag once a blanking window has passed, and steered so that lower pulses always alternate sides.

A control loop drives the duty command each period, a protection path drives the current-limit flag, and a supervisor drives the disable input. Charge length, deadtime length and the resonant-delay code are taken in once per bridge cycle, so a change made in mid-cycle never yields a malformed interval. The period strobe marks the first charge cycle of every oscillator period.

Top module: `zvs_bridge_pwm`

## Requirements
- R1: While reset is asserted all five outputs are low; in the first cycle after the first clock edge with reset released, an oscillator period begins with its strobe high.
- R2: Each oscillator period lasts C + D cycles, C charge cycles followed by D deadtime cycles (C and D being the sampled lengths); the strobe is high only in the first charge cycle of each period.
- R3: With disable low and the generator running, exactly one upper output is high; each upper output is high for C + D cycles of every bridge cycle, and upper-right is high throughout the charge of the left (even) period, upper-left throughout the charge of the right (odd) period.
- R4: With code k, the upper outputs swap floor(k*D/15) cycles before the deadtime ends, i.e. at deadtime offset D - floor(k*D/15) counted from 0; with k = 0 the swap coincides with the first charge cycle of the next period.
- R5: A resonant-delay code above 14 acts as 14, so the swap always falls after the start of the deadtime, when both lower outputs are already off.
- R6: A lower pulse starts only in the first charge cycle: lower-left in even periods (while upper-right is high), lower-right in odd periods; it lasts min(duty, C) cycles, and a duty of 0 gives no pulse.
- R7: A current-limit flag seen at charge offset 4 or later ends the active lower pulse in that same cycle and keeps it low for the rest of that charge; a flag at offsets 0 to 3 is ignored.
- R8: A current-limit cut affects only the period in which it occurs; the following period produces its full pulse.
- R9: A pulse whose side equals the side of the most recent issued lower pulse is suppressed for its whole period, so issued lower pulses always alternate left and right.
- R10: While disable is high all four gate outputs are low; the oscillator and strobe keep running.
- R11: C, D and the code are sampled at the start of each bridge cycle (start of an even period); changes in the inputs during a bridge cycle take effect from the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dis_i | input | 1 | Forces all gate outputs low |
| chg_len_i | input | CW | Charge interval length in cycles |
| dead_len_i | input | CW | Deadtime length in cycles |
| res_code_i | input | RW | Resonant-delay fraction, full scale 15 |
| duty_i | input | CW | Duty command, lower pulse width in cycles |
| ilim_i | input | 1 | Current-limit flag |
| up_l_o | output | 1 | Upper-left gate |
| up_r_o | output | 1 | Upper-right gate |
| lo_l_o | output | 1 | Lower-left gate |
| lo_r_o | output | 1 | Lower-right gate |
| stb_o | output | 1 | Period start strobe |

## Verification
The bench aims at the swap position inside the deadtime for a zero code, a mid code and a code above the clamp; a wrong scale or missing clamp moves the upper edge by whole cycles or lets it land on the deadtime start. It fires the current-limit flag both inside and past the blanking window, where a design without blanking truncates pulses early and one that latches the fault loses the next pulse. A skipped period followed by a same-side request checks pulse steering, which a plain period-parity design would break by issuing two left pulses in a row. Lengths changed in mid bridge cycle expose a design that samples them continuously through a shortened or stretched first period.

// File: rtl/zvs_bridge_pwm.sv
module zvs_bridge_pwm #(
  parameter int CW      = 8,
  parameter int RW      = 4,
  parameter int BLANK   = 4,
  parameter int RES_LIM = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dis_i,
  input  logic [CW-1:0] chg_len_i,
  input  logic [CW-1:0] dead_len_i,
  input  logic [RW-1:0] res_code_i,
  input  logic [CW-1:0] duty_i,
  input  logic          ilim_i,
  output logic          up_l_o,
  output logic          up_r_o,
  output logic          lo_l_o,
  output logic          lo_r_o,
  output logic          stb_o
);
  localparam int FS = (1 << RW) - 1;
  localparam int PW = CW + RW;

  logic          run_q, dead_q, side_q, allow_q, kill_q, last_q, have_q;
  logic [CW-1:0] cnt_q, chg_q, dlen_q, dly_q;

  logic [CW-1:0] chg_in, dead_in, dly_in, swap_at;
  logic [RW-1:0] res_eff;
  logic [PW-1:0] prod;
  logic          chg_end, dead_end, kill_now, act, ur_sel;

  assign chg_in  = (chg_len_i == '0) ? CW'(1) : chg_len_i;
  assign dead_in = (dead_len_i == '0) ? CW'(1) : dead_len_i;
  assign res_eff = (res_code_i > RW'(RES_LIM)) ? RW'(RES_LIM) : res_code_i;
  assign prod    = PW'(res_eff) * PW'(dead_in);
  assign dly_in  = CW'(prod / PW'(FS));
  assign swap_at = dlen_q - dly_q;

  assign chg_end  = !dead_q && (cnt_q == chg_q - CW'(1));
  assign dead_end = dead_q && (cnt_q == dlen_q - CW'(1));
  assign kill_now = run_q && !dead_q && ilim_i && (cnt_q >= CW'(BLANK));
  assign act      = run_q && !dis_i && !dead_q && allow_q && !kill_q && !kill_now
                    && (cnt_q < duty_i);
  assign ur_sel   = (dead_q && (cnt_q >= swap_at)) ? side_q : !side_q;

  assign up_r_o = run_q && !dis_i && ur_sel;
  assign up_l_o = run_q && !dis_i && !ur_sel;
  assign lo_l_o = act && !side_q;
  assign lo_r_o = act && side_q;
  assign stb_o  = run_q && !dead_q && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      dead_q  <= 1'b0;
      side_q  <= 1'b0;
      allow_q <= 1'b0;
      kill_q  <= 1'b0;
      last_q  <= 1'b0;
      have_q  <= 1'b0;
      cnt_q   <= '0;
      chg_q   <= CW'(1);
      dlen_q  <= CW'(1);
      dly_q   <= '0;
    end else if (!run_q) begin
      run_q   <= 1'b1;
      allow_q <= 1'b1;
      chg_q   <= chg_in;
      dlen_q  <= dead_in;
      dly_q   <= dly_in;
    end else begin
      if (act) begin
        last_q <= side_q;
        have_q <= 1'b1;
      end
      if (kill_now) kill_q <= 1'b1;
      if (chg_end) begin
        dead_q <= 1'b1;
        cnt_q  <= '0;
      end else if (dead_end) begin
        dead_q  <= 1'b0;
        cnt_q   <= '0;
        side_q  <= !side_q;
        kill_q  <= 1'b0;
        allow_q <= !have_q || (last_q == side_q);
        if (side_q) begin
          chg_q  <= chg_in;
          dlen_q <= dead_in;
          dly_q  <= dly_in;
        end
      end else begin
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end
endmodule

// File: rtl/zvs_bridge_pwm_chk.sv
module zvs_bridge_pwm_chk (
  input logic clk,
  input logic rst_n,
  input logic dis_i,
  input logic up_l_o,
  input logic up_r_o,
  input logic lo_l_o,
  input logic lo_r_o,
  input logic stb_o,
  input logic last_q,
  input logic have_q
);
  AST_UPPER_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(up_l_o && up_r_o)); // R3
  AST_DIAG_LEFT: assert property (@(posedge clk) disable iff (!rst_n) lo_l_o |-> up_r_o); // R6
  AST_DIAG_RIGHT: assert property (@(posedge clk) disable iff (!rst_n) lo_r_o |-> up_l_o); // R6
  AST_LOWER_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(lo_l_o && lo_r_o)); // R6
  AST_RISE_LEFT_AT_STB: assert property (@(posedge clk) disable iff (!rst_n) $rose(lo_l_o) |-> stb_o); // R6
  AST_RISE_RIGHT_AT_STB: assert property (@(posedge clk) disable iff (!rst_n) $rose(lo_r_o) |-> stb_o); // R6
  AST_DIS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    dis_i |-> !(up_l_o || up_r_o || lo_l_o || lo_r_o)); // R10
  AST_ALT_LEFT: assert property (@(posedge clk) disable iff (!rst_n) $rose(lo_l_o) |-> (!have_q || last_q)); // R9
  AST_ALT_RIGHT: assert property (@(posedge clk) disable iff (!rst_n) $rose(lo_r_o) |-> (!have_q || !last_q)); // R9
endmodule

bind zvs_bridge_pwm zvs_bridge_pwm_chk u_chk (
  .clk(clk), .rst_n(rst_n), .dis_i(dis_i),
  .up_l_o(up_l_o), .up_r_o(up_r_o), .lo_l_o(lo_l_o), .lo_r_o(lo_r_o),
  .stb_o(stb_o), .last_q(last_q), .have_q(have_q)
);

// File: tb/tb_zvs_bridge_pwm.sv
module tb_zvs_bridge_pwm;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       dis_i = 1'b0;
  logic [7:0] chg_len_i = 8'd1, dead_len_i = 8'd1, duty_i = 8'd0;
  logic [3:0] res_code_i = 4'd0;
  logic       ilim_i = 1'b0;
  logic       up_l_o, up_r_o, lo_l_o, lo_r_o, stb_o;

  int n_run = 0;
  int n_fail = 0;

  typedef struct {
    logic [7:0] chg, dead, duty;
    logic [3:0] res;
    logic       ilim, dis;
    logic [4:0] exp;
    string      tag;
  } item_t;

  item_t q[$];

  zvs_bridge_pwm dut (
    .clk(clk), .rst_n(rst_n), .dis_i(dis_i), .chg_len_i(chg_len_i),
    .dead_len_i(dead_len_i), .res_code_i(res_code_i), .duty_i(duty_i),
    .ilim_i(ilim_i), .up_l_o(up_l_o), .up_r_o(up_r_o), .lo_l_o(lo_l_o),
    .lo_r_o(lo_r_o), .stb_o(stb_o)
  );

  always #10 clk = !clk;

  // Driver: expected cycle-by-cycle items built from the requirements
  task automatic gen(input string tag, input int nb, input int c0, input int d0, input int r0,
                     input int c1, input int d1, input int r1, input int duty,
                     input int skipm, input int ilp, input int ilo, input bit dis);
    bit have = 0, last = 0, kill, allow;
    for (int b = 0; b < nb; b++) begin
      int c = (b == 0) ? c0 : c1;
      int d = (b == 0) ? d0 : d1;
      int r = (b == 0) ? r0 : r1;
      int rc = (r > 14) ? 14 : r;
      int dl = (rc * d) / 15;
      for (int s = 0; s < 2; s++) begin
        int p = 2 * b + s;
        int dt = ((skipm >> p) & 1) ? 0 : duty;
        allow = !have || (last != s[0]);
        kill = 0;
        for (int t = 0; t < c + d; t++) begin
          item_t it;
          bit dead = (t >= c);
          bit il = (p == ilp) && (t == ilo);
          bit ur = (dead && (t - c >= d - dl)) ? s[0] : !s[0];
          bit kn = !dead && il && (t >= 4);
          bit act = !dis && !dead && allow && !kill && !kn && (t < dt);
          if (kn) kill = 1;
          if (act) begin last = s[0]; have = 1; end
          it.chg  = 8'((s == 1) ? c1 : c);
          it.dead = 8'((s == 1) ? d1 : d);
          it.res  = 4'((s == 1) ? r1 : r);
          it.duty = 8'(dt);
          it.ilim = il;
          it.dis  = dis;
          it.exp  = {!dis && !ur, !dis && ur, act && (s == 0), act && (s == 1), t == 0};
          it.tag  = tag;
          q.push_back(it);
        end
      end
    end
  endtask

  // Monitor: applies each item's inputs, pops and compares outputs
  task automatic run_queue();
    int k = 0;
    chg_len_i = q[0].chg; dead_len_i = q[0].dead; res_code_i = q[0].res;
    duty_i = q[0].duty; ilim_i = 1'b0; dis_i = q[0].dis;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    n_run++;
    if ({up_l_o, up_r_o, lo_l_o, lo_r_o, stb_o} !== 5'b0) begin
      n_fail++;
      $display("FAIL R1 reset: got %b expected %b", {up_l_o, up_r_o, lo_l_o, lo_r_o, stb_o}, 5'b0);
    end
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    while (q.size() > 0) begin
      item_t it = q.pop_front();
      logic [4:0] got;
      @(negedge clk);
      chg_len_i = it.chg; dead_len_i = it.dead; res_code_i = it.res;
      duty_i = it.duty; ilim_i = it.ilim; dis_i = it.dis;
      #1;
      got = {up_l_o, up_r_o, lo_l_o, lo_r_o, stb_o};
      n_run++;
      if (got !== it.exp) begin
        n_fail++;
        $display("FAIL %s cycle %0d: got %b expected %b", it.tag, k, got, it.exp);
      end
      k++;
    end
    ilim_i = 1'b0;
  endtask

  initial begin
    // R1 R2 R3 R6: basic timing, zero code, mid duty
    gen("R1 R2 R3 R6 basic", 2, 10, 4, 0, 10, 4, 0, 6, 0, -1, 0, 0);
    run_queue();
    // R4: swap 4 cycles before deadtime end, duty above charge length
    gen("R4 R6 swap point", 2, 8, 10, 6, 8, 10, 6, 20, 0, -1, 0, 0);
    run_queue();
    // R5: code 15 behaves as 14
    gen("R5 code clamp", 2, 6, 15, 15, 6, 15, 15, 3, 0, -1, 0, 0);
    run_queue();
    // R7 R8: limit past blanking cuts pulse, next period normal
    gen("R7 R8 limit cut", 2, 12, 3, 3, 12, 3, 3, 10, 0, 1, 6, 0);
    run_queue();
    // R7: limit inside blanking ignored
    gen("R7 blanking", 1, 12, 3, 3, 12, 3, 3, 10, 0, 0, 2, 0);
    run_queue();
    // R9: period 1 skipped, period 2 left suppressed, then alternation resumes
    gen("R9 steering", 3, 6, 3, 0, 6, 3, 0, 4, 32'h2, -1, 0, 0);
    run_queue();
    // R6: zero duty
    gen("R6 zero duty", 1, 5, 2, 0, 5, 2, 0, 0, 0, -1, 0, 0);
    run_queue();
    // R10: disable
    gen("R10 disable", 1, 5, 3, 7, 5, 3, 7, 4, 0, -1, 0, 1);
    run_queue();
    // R11: new lengths driven mid bridge cycle apply from the next one
    gen("R11 sampling", 3, 6, 4, 0, 9, 5, 9, 5, 0, -1, 0, 0);
    run_queue();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 20);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule